// File: doc/BRIEF.md
# Status Register Write Guard

This block decides whether a request to rewrite the device status register is honoured, and runs the timed internal write that follows. A serial front end passes in two things. The first is a one-cycle request to set the write-enable latch. The second is a one-cycle request, with its data byte, saying that a complete status-write byte has arrived. The block also samples the chip-select line and the active-low write-protect pin. It produces a busy flag and the visible status byte.

A status write goes through three steps:

- The request is taken only when the write-enable latch is set and the protect pin is not in force. The pin is in force only when it is low and the protect-enable bit of the status register is one.
- An accepted request waits while chip select stays low. If the pin falls during that window, the request is cancelled.
- When chip select rises, the internal write cycle begins. It lasts a fixed number of clock cycles. Nothing on the pin can stop it once it has begun. At its end, the writable bits are updated and the write-enable latch clears.

Top module: `srg_top`

## Requirements
- R1: After reset the status output is 8'h00 and busy is low.
- R2: A status-write request made while the write-enable latch (status bit 1) is clear is ignored: no write cycle starts and the status is unchanged.
- R3: A completed write replaces only the writable bits 7, 3 and 2 with the request's data. Bits 6, 5 and 4 of the data are ignored. The write-enable latch (bit 1) clears at completion.
- R4: The write cycle starts on the first rising edge of chip select after an accepted request. Busy (also status bit 0) then stays high for exactly WC_CYCLES clock cycles.
- R5: With wp_n low and the protect-enable bit (status bit 7) one, every status-write request is refused: no cycle starts and the status is unchanged.
- R6: With the protect-enable bit zero, wp_n has no effect, so writes complete with wp_n held low.
- R7: If wp_n goes low while chip select is still low after an accepted request, and protect-enable is one, the request is cancelled: no cycle starts and the status is unchanged.
- R8: Once the write cycle has started, wp_n going low does not stop it or change the data written.
- R9: While busy, new status-write requests are ignored. No second cycle follows and the committed data is that of the first request.
- R10: A write-enable request sets bit 1 of the status while chip select is low and the block is not busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| wp_n | input | 1 | Write-protect pin, active low |
| wren_req | input | 1 | One-cycle request to set the write-enable latch |
| wrsr_req | input | 1 | One-cycle pulse: a complete status-write byte has arrived |
| wrsr_data | input | SR_W | Data byte for the status write |
| busy | output | 1 | Internal write cycle in progress |
| status | output | SR_W | Status byte: bit 0 busy, bit 1 write-enable latch, others stored |

## Verification
Writes are tried in four situations:

- With the latch clear, which separates the latch gate from the pin gate.
- With the pin high and low while protect-enable is one, which separates normal writes from blocked ones.
- With the pin falling before chip select rises and then after it rises, which tells a cancelled request from a cycle that must run to completion.
- With protect-enable cleared and the pin held low, which shows that the pin gate is conditional.

A data byte of all ones shows whether the read-only bits leak into the status. A second request issued mid-cycle shows whether the busy window really ignores input.

// File: rtl/srg_pkg.sv
package srg_pkg;
  typedef enum logic [1:0] {
    SRG_IDLE  = 2'd0,
    SRG_ARMED = 2'd1,
    SRG_CYCLE = 2'd2
  } srg_state_e;

  function automatic logic pin_protects(input logic wp_n, input logic wpen);
    return (!wp_n) && wpen;
  endfunction

  function automatic logic [7:0] merge_bits(input logic [7:0] old_v,
                                            input logic [7:0] new_v,
                                            input logic [7:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction
endpackage

// File: rtl/srg_arbiter.sv
module srg_arbiter
  import srg_pkg::*;
#(
  parameter int SR_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            cs_rise,
  input  logic            wp_n,
  input  logic            wpen,
  input  logic            wel,
  input  logic            wrsr_req,
  input  logic [SR_W-1:0] wrsr_data,
  input  logic            cycle_done,
  output logic            accept,
  output logic            cancel,
  output logic            start,
  output logic            in_cycle,
  output logic [SR_W-1:0] held_data
);
  srg_state_e state_q, state_d;
  logic       guard;

  assign guard  = pin_protects(wp_n, wpen);
  assign accept = (state_q == SRG_IDLE) && wrsr_req && !cs_n && wel && !guard;
  assign cancel = (state_q == SRG_ARMED) && !cs_n && guard;
  assign start  = (state_q == SRG_ARMED) && cs_rise;
  assign in_cycle = (state_q == SRG_CYCLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      SRG_IDLE:  if (accept) state_d = SRG_ARMED;
      SRG_ARMED: begin
        if (cancel)     state_d = SRG_IDLE;
        else if (start) state_d = SRG_CYCLE;
      end
      SRG_CYCLE: if (cycle_done) state_d = SRG_IDLE;
      default:   state_d = SRG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SRG_IDLE;
      held_data <= '0;
    end else begin
      state_q <= state_d;
      if (accept) held_data <= wrsr_data;
    end
  end

  p_accept_unprotected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !(!wp_n && wpen));
  p_accept_needs_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> wel);
  p_start_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (cs_n && $past(!cs_n)));
  p_cycle_no_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_cycle |-> !cancel && !accept);
endmodule

// File: rtl/srg_timer.sv
module srg_timer #(
  parameter int WC_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(WC_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WC_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= LOAD;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_count_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= LOAD));
  p_count_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy && (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/srg_store.sv
module srg_store
  import srg_pkg::*;
#(
  parameter int          SR_W    = 8,
  parameter logic [7:0]  WR_MASK = 8'h8C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            latch_set,
  input  logic            commit,
  input  logic [SR_W-1:0] commit_data,
  output logic [SR_W-1:0] stored,
  output logic            wel
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored <= '0;
      wel    <= 1'b0;
    end else begin
      if (commit) begin
        stored <= merge_bits(stored, commit_data, WR_MASK);
        wel    <= 1'b0;
      end else if (latch_set) begin
        wel <= 1'b1;
      end
    end
  end

  p_hold_unless_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(stored));
  p_latch_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !wel);
  p_readonly_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((stored & ~WR_MASK) == '0));
endmodule

// File: rtl/srg_top.sv
module srg_top
  import srg_pkg::*;
#(
  parameter int         SR_W      = 8,
  parameter logic [7:0] WR_MASK   = 8'h8C,
  parameter int         WPEN_BIT  = 7,
  parameter int         WC_CYCLES = 500000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            wp_n,
  input  logic            wren_req,
  input  logic            wrsr_req,
  input  logic [SR_W-1:0] wrsr_data,
  output logic            busy,
  output logic [SR_W-1:0] status
);
  localparam int BUSY_BIT = 0;
  localparam int WEL_BIT  = 1;

  logic            cs_n_q;
  logic            cs_rise;
  logic            accept, cancel, start, in_cycle, done;
  logic            wel, latch_set;
  logic [SR_W-1:0] held_data, stored;

  always_ff @(posedge clk) begin
    if (!rst_n) cs_n_q <= 1'b1;
    else        cs_n_q <= cs_n;
  end

  assign cs_rise   = cs_n && !cs_n_q;
  assign latch_set = wren_req && !cs_n && !busy;

  srg_arbiter #(.SR_W(SR_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_rise(cs_rise), .wp_n(wp_n),
    .wpen(stored[WPEN_BIT]), .wel(wel), .wrsr_req(wrsr_req),
    .wrsr_data(wrsr_data), .cycle_done(done), .accept(accept),
    .cancel(cancel), .start(start), .in_cycle(in_cycle), .held_data(held_data)
  );

  srg_timer #(.WC_CYCLES(WC_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
  );

  srg_store #(.SR_W(SR_W), .WR_MASK(WR_MASK)) u_st (
    .clk(clk), .rst_n(rst_n), .latch_set(latch_set), .commit(done),
    .commit_data(held_data), .stored(stored), .wel(wel)
  );

  always_comb begin
    status           = stored;
    status[BUSY_BIT] = busy;
    status[WEL_BIT]  = wel;
  end

  p_busy_tracks_fsm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy == in_cycle);
  p_no_cycle_without_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
  p_latch_set_visible_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_set && !done) |=> status[WEL_BIT]);
endmodule

// File: tb/srg_top_bench.sv
module srg_top_bench;
  localparam int WC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       wp_n = 1'b1;
  logic       wren_req = 1'b0;
  logic       wrsr_req = 1'b0;
  logic [7:0] wrsr_data = 8'h00;
  logic       busy;
  logic [7:0] status;

  int checks = 0;
  int failures = 0;

  typedef struct { string tag; logic [7:0] exp; } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  srg_top #(.WC_CYCLES(WC)) u_srg_top (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .wren_req(wren_req),
    .wrsr_req(wrsr_req), .wrsr_data(wrsr_data), .busy(busy), .status(status)
  );

  // bench-side status model: writable bits 7,3,2; bit1 latch; bit0 busy
  logic [7:0] m_bits = 8'h00;
  logic       m_wel  = 1'b0;

  function automatic logic [7:0] model_view(input logic [7:0] b, input logic w);
    return b | (w ? 8'h02 : 8'h00);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_status(input string tag);
    exp_t e;
    e.tag = tag;
    e.exp = model_view(m_bits, m_wel);
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: pops expected items and compares against the design's status
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tag, int'(status), int'(e.exp));
    end
  end

  task automatic do_wren();
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk) wren_req = 1'b1;
    @(negedge clk) wren_req = 1'b0;
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
  endtask

  // mid: 0 none, 1 drop wp_n before cs rises, 2 drop wp_n during busy,
  //      3 extra request during busy
  task automatic do_wrsr(input logic [7:0] d, input int mid, output int bcyc);
    bcyc = 0;
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk) begin wrsr_req = 1'b1; wrsr_data = d; end
    @(negedge clk) wrsr_req = 1'b0;
    if (mid == 1) @(negedge clk) wp_n = 1'b0;
    @(negedge clk) cs_n = 1'b1;
    for (int i = 0; i < WC + 6; i++) begin
      @(negedge clk);
      if (busy) bcyc++;
      if (mid == 2 && i == 2) wp_n = 1'b0;
      if (mid == 3 && i == 1) cs_n = 1'b0;
      if (mid == 3 && i == 2) begin wrsr_req = 1'b1; wrsr_data = 8'h00; end
      if (mid == 3 && i == 3) wrsr_req = 1'b0;
      if (mid == 3 && i == 4) cs_n = 1'b1;
    end
  endtask

  initial begin : watchdog
    #(4 * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : driver
    int bc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    expect_status("R1 status after reset");

    // R2: no latch, request ignored
    do_wrsr(8'h8C, 0, bc);
    chk("R2 no cycle without latch", bc, 0);
    expect_status("R2 status unchanged");

    // R10 then R3/R4: normal write with all-ones data
    do_wren();
    m_wel = 1'b1;
    expect_status("R10 latch set");
    do_wrsr(8'hFF, 0, bc);
    chk("R4 busy length", bc, WC);
    m_bits = 8'h8C; m_wel = 1'b0;
    expect_status("R3 writable bits only, latch cleared");

    // R5: pin low with protect enabled
    wp_n = 1'b0;
    do_wren();
    m_wel = 1'b1;
    do_wrsr(8'h00, 0, bc);
    chk("R5 blocked no cycle", bc, 0);
    expect_status("R5 status unchanged");

    // R7: pin falls while cs low -> cancel
    wp_n = 1'b1;
    @(negedge clk);
    do_wrsr(8'h88, 1, bc);
    chk("R7 cancelled no cycle", bc, 0);
    expect_status("R7 status unchanged");

    // R8: pin falls after cycle began
    wp_n = 1'b1;
    @(negedge clk);
    do_wrsr(8'h84, 2, bc);
    chk("R8 cycle runs to end", bc, WC);
    m_bits = 8'h84; m_wel = 1'b0;
    expect_status("R8 data committed");

    // R9: extra request while busy
    wp_n = 1'b1;
    do_wren();
    m_wel = 1'b1;
    do_wrsr(8'h8C, 3, bc);
    chk("R9 single cycle only", bc, WC);
    m_bits = 8'h8C; m_wel = 1'b0;
    expect_status("R9 first data kept");
    repeat (3) @(negedge clk);
    chk("R9 no second cycle", int'(busy), 0);

    // R6: protect-enable cleared, pin low has no effect
    do_wren();
    do_wrsr(8'h0C, 0, bc);
    m_bits = 8'h0C; m_wel = 1'b0;
    expect_status("R6 protect-enable cleared");
    wp_n = 1'b0;
    do_wren();
    do_wrsr(8'h08, 0, bc);
    chk("R6 cycle with pin low", bc, WC);
    m_bits = 8'h08;
    expect_status("R6 write with pin low");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule